// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner with Transfer Strobe

This block presents a four-and-a-half digit decimal result one digit at a time. A shared 4-bit BCD bus carries the digit, and five one-hot, active-high digit-select lines name the digit on the bus. The most significant digit is a half digit, so its value is only 0 or 1. The scan runs from the most significant position down to the least and then starts again. It never stops, so a multiplexed display stays lit between conversions. The block does not decode the digits for a display, drive segments or perform the conversion.

When the sequencer reports a finished conversion, the block captures the new digits and the overrange flag. The scan restarts at the most significant digit in the next cycle. During the next five digit slots the block pulses an active-low strobe once in the middle of each slot, so an external latch, UART or processor can pick up each digit. Later scans carry no strobe. After an overrange conversion the bus reads zero. After the fifth strobe the digit selects are forced low until the sequencer reports the start of the next reference-integration phase, which makes the display blink.

Top module: `adc_digit_scanner`

## Requirements
- R1: While reset is high, the digit select shows only the most significant slot (`dig_sel_o` = 5'b10000), `bcd_o` is 0 and `strobe_n_o` is 1.
- R2: `dig_sel_o` is one-hot or all zero. Bit 4 selects the most significant digit and bit 0 the least significant. The slots follow in the order bit 4, 3, 2, 1, 0 and then return to bit 4.
- R3: Each slot for bits 3..0 lasts SLOT_LEN clocks. The slot for bit 4 lasts SLOT_LEN+MSD_EXTRA clocks.
- R4: In the clock after `conv_done_i` is sampled high, the scan is in the first clock of the bit-4 slot and the bus shows the newly captured value.
- R5: After a conversion, the strobe goes low for exactly one clock. This happens STB_OFS+MSD_EXTRA clocks into the bit-4 slot and STB_OFS clocks into each of the slots for bits 3..0.
- R6: Each conversion produces exactly five strobe pulses. No strobe appears before the first conversion or after the fifth pulse until the next `conv_done_i`.
- R7: In the bit-4 slot the bus reads {3'b000, msd}. In the slot for bit k (k = 3..0), the bus reads `low_digits_i[4k+3:4k]` as captured. The bus changes in the same clock as the digit select.
- R8: After a conversion captured with `over_i` high, `bcd_o` reads 0 until the next conversion is captured.
- R9: After an overrange conversion, `dig_sel_o` is all zero from the clock after the fifth strobe until the clock after `refint_start_i` is sampled high, or until a new conversion restarts the scan. Scan timing keeps running during blanking. A `refint_start_i` pulse at any other time has no effect on the outputs.
- R10: A change of `msd_i`, `low_digits_i` or `over_i` while `conv_done_i` is low has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done_i | input | 1 | One-clock pulse: the conversion result is valid, capture it and restart the scan |
| msd_i | input | 1 | Half digit (0 or 1) of the result |
| low_digits_i | input | 16 | Four full BCD digits. The least significant digit is in bits 3:0 |
| over_i | input | 1 | Overrange flag of the result |
| refint_start_i | input | 1 | Pulse at the start of a reference-integration phase; ends blanking |
| dig_sel_o | output | 5 | One-hot digit select, active high |
| bcd_o | output | 4 | Multiplexed BCD digit, positive true |
| strobe_n_o | output | 1 | Active-low transfer strobe, one clock wide |

## Verification
The hardest state to reach from the ports is overrange blanking. It exists only after the fifth strobe of an overrange conversion, and it ends only through the reference-start pulse or a new conversion. The bench uses a short slot length. It issues overrange conversions with the reference pulse placed before the last strobe, after it, and not at all. It compares every clock against an arithmetic model of slot, position and blanking. The bench also scrambles the data inputs right after every capture. It restarts conversions mid-scan to confirm that only the capture cycle loads data and rearms the strobe.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  // Width of the in-slot position counter: holds 0 .. SLOT_LEN+MSD_EXTRA-1.
  function automatic int cnt_w(input int slot_len, input int msd_extra);
    return $clog2(slot_len + msd_extra);
  endfunction

  // Width of the slot index: holds 0 .. NDIG-1.
  function automatic int slot_w(input int ndig);
    return $clog2(ndig);
  endfunction
endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int NDIG      = 5,
  parameter int SLOT_LEN  = 200,
  parameter int MSD_EXTRA = 1,
  parameter int CW        = adc_scan_pkg::cnt_w(SLOT_LEN, MSD_EXTRA),
  parameter int SW        = adc_scan_pkg::slot_w(NDIG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  output logic [SW-1:0] slot_q,
  output logic [CW-1:0] cnt_q,
  output logic [SW-1:0] slot_n,
  output logic [CW-1:0] cnt_n
);
  localparam logic [CW-1:0] LAST_MSD  = CW'(SLOT_LEN + MSD_EXTRA - 1);
  localparam logic [CW-1:0] LAST_STD  = CW'(SLOT_LEN - 1);
  localparam logic [SW-1:0] LAST_SLOT = SW'(NDIG - 1);

  logic [CW-1:0] slot_end;

  always_comb begin
    slot_end = (slot_q == '0) ? LAST_MSD : LAST_STD;
    slot_n   = slot_q;
    cnt_n    = cnt_q + CW'(1);
    if (restart) begin
      slot_n = '0;
      cnt_n  = '0;
    end else if (cnt_q == slot_end) begin
      cnt_n  = '0;
      slot_n = (slot_q == LAST_SLOT) ? '0 : slot_q + SW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      cnt_q  <= '0;
    end else begin
      slot_q <= slot_n;
      cnt_q  <= cnt_n;
    end
  end
endmodule

// File: rtl/strobe_gen.sv
module strobe_gen #(
  parameter int NDIG      = 5,
  parameter int STB_OFS   = 100,
  parameter int MSD_EXTRA = 1,
  parameter int CW        = 8,
  parameter int SW        = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic [SW-1:0] slot_q,
  input  logic [CW-1:0] cnt_q,
  input  logic [SW-1:0] slot_n,
  input  logic [CW-1:0] cnt_n,
  output logic          strobe_n,
  output logic          final_fire
);
  localparam logic [CW-1:0] POS_MSD   = CW'(STB_OFS + MSD_EXTRA);
  localparam logic [CW-1:0] POS_STD   = CW'(STB_OFS);
  localparam logic [SW-1:0] LAST_SLOT = SW'(NDIG - 1);

  logic          armed_q, armed_n;
  logic [CW-1:0] pos_n;

  // Current state is the strobe clock of the last digit of an armed run.
  assign final_fire = armed_q && (slot_q == LAST_SLOT) && (cnt_q == POS_STD);

  always_comb begin
    armed_n = arm ? 1'b1 : (armed_q && !final_fire);
    pos_n   = (slot_n == '0) ? POS_MSD : POS_STD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q  <= 1'b0;
      strobe_n <= 1'b1;
    end else begin
      armed_q  <= armed_n;
      strobe_n <= !(armed_n && (cnt_n == pos_n));
    end
  end
endmodule

// File: rtl/digit_mux.sv
module digit_mux #(
  parameter int NDIG = 5,
  parameter int DW   = 4,
  parameter int SW   = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic                   ms_i,
  input  logic [(NDIG-1)*DW-1:0] lo_i,
  input  logic                   ovr_i,
  input  logic                   blank_n,
  input  logic [SW-1:0]          slot_n,
  output logic [NDIG-1:0]        dig_o,
  output logic [DW-1:0]          bcd_o,
  output logic                   ovr_q
);
  localparam int              NSEL    = 1 << SW;
  localparam logic [NDIG-1:0] MSD_SEL = {1'b1, {(NDIG-1){1'b0}}};

  logic                   ms_q, ms_nx, ovr_nx;
  logic [(NDIG-1)*DW-1:0] lo_q, lo_nx;
  logic [DW-1:0]          pick [NSEL];
  logic [NDIG-1:0]        hot;

  assign ms_nx  = load ? ms_i  : ms_q;
  assign lo_nx  = load ? lo_i  : lo_q;
  assign ovr_nx = load ? ovr_i : ovr_q;

  for (genvar g = 0; g < NSEL; g++) begin : g_pick
    if (g == 0) begin : g_msd
      assign pick[g] = {{(DW-1){1'b0}}, ms_nx};
    end else if (g < NDIG) begin : g_low
      assign pick[g] = lo_nx[DW*(NDIG-1-g) +: DW];
    end else begin : g_none
      assign pick[g] = '0;
    end
  end

  for (genvar g = 0; g < NDIG; g++) begin : g_hot
    assign hot[NDIG-1-g] = (slot_n == SW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ms_q  <= 1'b0;
      lo_q  <= '0;
      ovr_q <= 1'b0;
      dig_o <= MSD_SEL;
      bcd_o <= '0;
    end else begin
      ms_q  <= ms_nx;
      lo_q  <= lo_nx;
      ovr_q <= ovr_nx;
      dig_o <= blank_n ? '0 : hot;
      bcd_o <= ovr_nx ? '0 : pick[slot_n];
    end
  end
endmodule

// File: rtl/adc_digit_scanner.sv
module adc_digit_scanner #(
  parameter int NDIG      = 5,
  parameter int DW        = 4,
  parameter int SLOT_LEN  = 200,
  parameter int STB_OFS   = 100,
  parameter int MSD_EXTRA = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   conv_done_i,
  input  logic                   msd_i,
  input  logic [(NDIG-1)*DW-1:0] low_digits_i,
  input  logic                   over_i,
  input  logic                   refint_start_i,
  output logic [NDIG-1:0]        dig_sel_o,
  output logic [DW-1:0]          bcd_o,
  output logic                   strobe_n_o
);
  localparam int CW = adc_scan_pkg::cnt_w(SLOT_LEN, MSD_EXTRA);
  localparam int SW = adc_scan_pkg::slot_w(NDIG);

  logic [SW-1:0] slot_q, slot_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          final_fire, ovr_q;
  logic          blank_q, blank_n;

  scan_timer #(
    .NDIG(NDIG), .SLOT_LEN(SLOT_LEN), .MSD_EXTRA(MSD_EXTRA), .CW(CW), .SW(SW)
  ) u_timer (
    .clk(clk), .rst(rst), .restart(conv_done_i),
    .slot_q(slot_q), .cnt_q(cnt_q), .slot_n(slot_n), .cnt_n(cnt_n)
  );

  strobe_gen #(
    .NDIG(NDIG), .STB_OFS(STB_OFS), .MSD_EXTRA(MSD_EXTRA), .CW(CW), .SW(SW)
  ) u_strobe (
    .clk(clk), .rst(rst), .arm(conv_done_i),
    .slot_q(slot_q), .cnt_q(cnt_q), .slot_n(slot_n), .cnt_n(cnt_n),
    .strobe_n(strobe_n_o), .final_fire(final_fire)
  );

  // Blanking: set after the last strobe of an overrange result,
  // cleared by the reference-integration start or a new result.
  always_comb begin
    if (conv_done_i || refint_start_i) blank_n = 1'b0;
    else                               blank_n = blank_q || (final_fire && ovr_q);
  end

  always_ff @(posedge clk) begin
    if (rst) blank_q <= 1'b0;
    else     blank_q <= blank_n;
  end

  digit_mux #(
    .NDIG(NDIG), .DW(DW), .SW(SW)
  ) u_mux (
    .clk(clk), .rst(rst), .load(conv_done_i),
    .ms_i(msd_i), .lo_i(low_digits_i), .ovr_i(over_i),
    .blank_n(blank_n), .slot_n(slot_n),
    .dig_o(dig_sel_o), .bcd_o(bcd_o), .ovr_q(ovr_q)
  );
endmodule

// File: rtl/scan_checker.sv
module scan_checker #(
  parameter int NDIG = 5,
  parameter int DW   = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            conv_done_i,
  input logic            over_i,
  input logic            refint_start_i,
  input logic [NDIG-1:0] dig_sel_o,
  input logic [DW-1:0]   bcd_o,
  input logic            strobe_n_o
);
  localparam logic [NDIG-1:0] MSD_SEL = {1'b1, {(NDIG-1){1'b0}}};
  localparam logic [NDIG-1:0] LSD_SEL = {{(NDIG-1){1'b0}}, 1'b1};

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (dig_sel_o == MSD_SEL && bcd_o == '0 && strobe_n_o));

  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dig_sel_o));

  a_r2_order: assert property (@(posedge clk) disable iff (rst)
    (!$past(conv_done_i) && $past(dig_sel_o) != '0 && dig_sel_o != '0 &&
     dig_sel_o != $past(dig_sel_o))
    |-> (dig_sel_o == ($past(dig_sel_o) >> 1) ||
         ($past(dig_sel_o) == LSD_SEL && dig_sel_o == MSD_SEL)));

  a_r4_restart_msd: assert property (@(posedge clk) disable iff (rst)
    conv_done_i |=> dig_sel_o == MSD_SEL);

  a_r5_strobe_one_clock: assert property (@(posedge clk) disable iff (rst)
    !strobe_n_o |=> strobe_n_o);

  a_r7_half_digit: assert property (@(posedge clk) disable iff (rst)
    dig_sel_o[NDIG-1] |-> bcd_o[DW-1:1] == '0);

  a_r8_over_zero: assert property (@(posedge clk) disable iff (rst)
    (conv_done_i && over_i) |=> bcd_o == '0);

  a_r9_blank_hold: assert property (@(posedge clk) disable iff (rst)
    (dig_sel_o == '0 && !conv_done_i && !refint_start_i) |=> dig_sel_o == '0);
endmodule

bind adc_digit_scanner scan_checker #(.NDIG(NDIG), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .conv_done_i(conv_done_i), .over_i(over_i),
  .refint_start_i(refint_start_i), .dig_sel_o(dig_sel_o), .bcd_o(bcd_o),
  .strobe_n_o(strobe_n_o)
);

// File: tb/sim_adc_digit_scanner.sv
`timescale 1ns/1ps
module sim_adc_digit_scanner;
  localparam int NDIG = 5, DW = 4, SLOT = 6, STB = 3, EXTRA = 1;
  localparam int MSDLEN  = SLOT + EXTRA;
  localparam int PERIOD  = MSDLEN + (NDIG-1)*SLOT;
  localparam int LASTSTB = MSDLEN + (NDIG-2)*SLOT + STB;

  logic clk = 1'b0, rst = 1'b1, conv = 1'b0, ms = 1'b0, ovr = 1'b0, refs = 1'b0;
  logic [15:0] lo = '0;
  logic [4:0]  dig;
  logic [3:0]  bcd;
  logic        stb_n;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adc_digit_scanner #(.NDIG(NDIG), .DW(DW), .SLOT_LEN(SLOT), .STB_OFS(STB),
                      .MSD_EXTRA(EXTRA)) u0 (
    .clk(clk), .rst(rst), .conv_done_i(conv), .msd_i(ms), .low_digits_i(lo),
    .over_i(ovr), .refint_start_i(refs), .dig_sel_o(dig), .bcd_o(bcd),
    .strobe_n_o(stb_n));

  task automatic cmp(input string req, input int act, input int exp, input int t);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s t=%0d actual=%0h expected=%0h", req, t, act, exp);
    end
  endtask

  // Compare every clock of a window against the arithmetic model.
  task automatic check_window(input int t0, input int n, input bit armed,
                              input bit e_ms, input logic [15:0] e_lo,
                              input bit e_ovr, input int ref_t);
    int nstb = 0;
    for (int t = t0; t < n; t++) begin
      int p, slot, c, e_bcd;
      bit e_stb, e_blank;
      logic [4:0] e_dig;
      if (t != t0) @(negedge clk);
      if (t == 0) begin
        conv = 1'b0;
        ms = ~e_ms; lo = ~e_lo; ovr = ~e_ovr;   // R10: ignored until next capture
      end
      p     = t % PERIOD;
      slot  = (p < MSDLEN) ? 0 : 1 + (p - MSDLEN) / SLOT;
      c     = (p < MSDLEN) ? p : (p - MSDLEN) % SLOT;
      e_stb = armed && (t < PERIOD) && (c == ((slot == 0) ? STB + EXTRA : STB));
      e_blank = e_ovr && (t > LASTSTB) && !(ref_t > LASTSTB && t > ref_t);
      e_dig = e_blank ? 5'b0 : (5'b10000 >> slot);
      e_bcd = e_ovr ? 0 : (slot == 0) ? int'(e_ms) : int'(e_lo[4*(4-slot) +: 4]);
      cmp(e_blank || e_ovr ? "R9 digit select (R2 R3)" : "R2 R3 digit select",
          dig, e_dig, t);
      cmp(e_ovr ? "R8 bcd" : "R7 R10 bcd", bcd, e_bcd, t);
      cmp("R5 strobe", stb_n, !e_stb, t);
      if (!stb_n) nstb++;
      refs = (t == ref_t);
    end
    refs = 1'b0;
    if (n - t0 >= 2*PERIOD) cmp("R6 strobe count", nstb, armed ? 5 : 0, n);
  endtask

  task automatic conversion(input bit e_ms, input logic [15:0] e_lo,
                            input bit e_ovr, input int ref_t, input int n);
    @(negedge clk);
    conv = 1'b1; ms = e_ms; lo = e_lo; ovr = e_ovr;
    @(negedge clk);
    // R4: first clock after capture is the MSD slot with the new value
    cmp("R4 restart select", dig, 5'b10000, 0);
    check_window(0, n, 1'b1, e_ms, e_lo, e_ovr, ref_t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1 reset select", dig, 5'b10000, 0);
    cmp("R1 reset bcd", bcd, 0, 0);
    cmp("R1 reset strobe", stb_n, 1, 0);
    rst = 1'b0;
    @(negedge clk);
    check_window(1, 2*PERIOD + 4, 1'b0, 1'b0, 16'h0, 1'b0, -1);
    // Sweep digit patterns with both half-digit values
    for (int m = 0; m < 2; m++)
      for (int v = 0; v < 10; v++)
        conversion(m[0], {4'(v), 4'(9 - v), 4'((v + 3) % 10), 4'((v + 7) % 10)},
                   1'b0, -1, PERIOD + 8);
    // Full windows for the strobe count, with an unrelated reference pulse
    conversion(1'b1, 16'h9876, 1'b0, 40, 2*PERIOD + 5);
    // Mid-scan restarts
    conversion(1'b0, 16'h1234, 1'b0, -1, 13);
    conversion(1'b1, 16'h5678, 1'b0, -1, 2*PERIOD + 3);
    // Overrange: reference start after, before, and missing
    conversion(1'b1, 16'h4321, 1'b1, LASTSTB + 17, 2*PERIOD + 10);
    conversion(1'b0, 16'h2468, 1'b1, LASTSTB - 10, 2*PERIOD + 6);
    conversion(1'b1, 16'h1357, 1'b1, -1, 2*PERIOD + 6);
    // New capture ends blanking on its own
    conversion(1'b0, 16'h9090, 1'b0, -1, 2*PERIOD + 2);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule